// File: doc/BRIEF.md
# Comparator Hit Detection Logic

This block sits between a bank of asynchronous comparator outputs and a latency pipeline memory. For every channel it makes one clocked hit bit per system clock (40 MHz in the target system), and that bit is written into the pipeline on every cycle. All channels share a single mode input, which selects one of two behaviours.

In level mode the hit bit is simply the comparator level, brought into the clock domain through a synchroniser. A pulse that rises and falls between two clock edges is lost, and that is accepted. In one-shot mode every comparator pulse gives exactly one clock cycle of hit. A pulse shorter than a clock is stretched, because an edge-capture flop is set asynchronously by the rising edge. A long pulse is compressed, because the channel does not re-arm until the comparator has gone low again. The captured edge and the level each pass through a synchroniser before any logic reads them, and the edge-capture flop is cleared once its hit has been issued.

Top module: `hit_detect_array`

## Requirements
- R1: While `rst` is high, every bit of `hit_out` is 0 after the next clock edge. `hit_out` stays 0 for the first two clock edges after `rst` is released.
- R2: With `level_mode`=1, `hit_out[i]` after clock edge t equals `comp_in[i]` as sampled at edge t-2.
- R3: With `level_mode`=1, a pulse on `comp_in[i]` that both starts and ends between two consecutive clock edges produces no hit.
- R4: With `level_mode`=0, a rising edge of `comp_in[i]` that arrives between edge k-1 and edge k makes `hit_out[i]`=1 after edge k+2, for exactly one cycle. This also holds when the pulse ends before edge k.
- R5: With `level_mode`=0, a pulse held high across any number of edges produces only the single hit of R4.
- R6: With `level_mode`=0, a channel re-arms after a hit. A new pulse whose rise is at least 6 cycles after the previous rise and at least 3 cycles after the previous fall produces its own hit, with the R4 timing.
- R7: Channels are independent. A pulse on one channel never produces a hit on another, and channels hit at their own times under the shared mode.
- R8: With `level_mode`=0, a comparator that is already high when reset is released produces no hit until it has fallen and risen again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| level_mode | input | 1 | 1 = synchronised level, 0 = one clock of hit per pulse; shared by all channels |
| comp_in | input | NCH | Asynchronous comparator outputs, one per channel |
| hit_out | output | NCH | Registered hit bits for the pipeline, one per channel |

## Verification
Both modes show a result on the third clock edge that follows the input. In level mode this means the level sampled at edge t appears after edge t+2. In one-shot mode a rise just before edge k appears after edge k+2, for one cycle. The bench changes comparator inputs a fraction of a cycle after a falling edge and reads `hit_out` at falling edges, so every check falls in a well-defined cycle. It compares level mode against its own three-deep record of the inputs taken at rising edges. It compares one-shot mode against a window of cycles counted from the edge that follows the rise, with a one at offset 2 and zeros everywhere else.

// File: rtl/hit_detect_pkg.sv
package hit_detect_pkg;

  // Clock edges from the first sampling edge until the hit bit shows it.
  function automatic int unsigned hit_latency(input int unsigned sync_depth);
    return sync_depth;
  endfunction

  // Cycles after a hit before the channel may re-arm: the cleared edge flop
  // must first have flushed through the synchroniser.
  function automatic int unsigned rearm_hold(input int unsigned sync_depth);
    return sync_depth + 1;
  endfunction

endpackage

// File: rtl/hit_edge_latch.sv
module hit_edge_latch (
  input  logic trig,
  input  logic clr,
  output logic q
);
  // Set by a rising edge of the comparator, cleared asynchronously by clr.
  always_ff @(posedge trig or posedge clr) begin
    if (clr) q <= 1'b0;
    else     q <= 1'b1;
  end
endmodule

// File: rtl/hit_sync.sv
module hit_sync #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < DEPTH; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < DEPTH; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/hit_chan.sv
module hit_chan
  import hit_detect_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic level_mode,
  input  logic comp,
  output logic hit,
  output logic fire_o,
  output logic armed_o
);
  localparam int HOLD = int'(rearm_hold(SYNC_DEPTH));
  localparam int HW   = $clog2(HOLD + 1);

  logic          cap_q;
  logic          cap_clr_q;
  logic          cap_seen;
  logic          lvl_seen;
  logic          armed_q;
  logic          hit_q;
  logic [HW-1:0] hold_q;
  logic          fire;

  hit_edge_latch u_cap (
    .trig (comp),
    .clr  (cap_clr_q),
    .q    (cap_q)
  );

  hit_sync #(.W(1), .DEPTH(SYNC_DEPTH)) u_cap_sync (
    .clk (clk), .rst (rst), .d (cap_q), .q (cap_seen)
  );

  hit_sync #(.W(1), .DEPTH(SYNC_DEPTH)) u_lvl_sync (
    .clk (clk), .rst (rst), .d (comp), .q (lvl_seen)
  );

  assign fire = cap_seen & armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_clr_q <= 1'b1;
      armed_q   <= 1'b0;
      hold_q    <= '0;
      hit_q     <= 1'b0;
    end else begin
      cap_clr_q <= fire;
      hit_q     <= level_mode ? lvl_seen : fire;
      if (fire) begin
        armed_q <= 1'b0;
        hold_q  <= HW'(HOLD);
      end else begin
        if (hold_q != '0) hold_q <= hold_q - 1'b1;
        if (hold_q == '0 && !lvl_seen) armed_q <= 1'b1;
      end
    end
  end

  assign hit     = hit_q;
  assign fire_o  = fire;
  assign armed_o = armed_q;
endmodule

// File: rtl/hit_detect_array.sv
module hit_detect_array #(
  parameter int NCH        = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           level_mode,
  input  logic [NCH-1:0] comp_in,
  output logic [NCH-1:0] hit_out
);
  logic [NCH-1:0] fire_vec;
  logic [NCH-1:0] armed_vec;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    hit_chan #(.SYNC_DEPTH(SYNC_DEPTH)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .level_mode (level_mode),
      .comp       (comp_in[c]),
      .hit        (hit_out[c]),
      .fire_o     (fire_vec[c]),
      .armed_o    (armed_vec[c])
    );
  end
endmodule

// File: rtl/hit_detect_checker.sv
module hit_detect_checker
  import hit_detect_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int SYNC_DEPTH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           level_mode,
  input logic [NCH-1:0] comp_in,
  input logic [NCH-1:0] hit_out,
  input logic [NCH-1:0] fire_vec
);
  localparam int LAT = int'(hit_latency(SYNC_DEPTH));

  logic [3:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 4'hF) age <= age + 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> hit_out == '0);

  // R1
  release_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(age) <= LAT) |-> hit_out == '0);

  // R2
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(age) > LAT && $past(level_mode)) |-> hit_out == $past(comp_in, SYNC_DEPTH + 1));

  // R4
  single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(age) > LAT && !$past(level_mode) && !$past(level_mode, 2))
      |-> (hit_out & $past(hit_out)) == '0);

  // R5
  fire_once_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(age) > 0) |-> (fire_vec & $past(fire_vec)) == '0);
endmodule

bind hit_detect_array hit_detect_checker #(.NCH(NCH), .SYNC_DEPTH(SYNC_DEPTH)) u_hit_chk (
  .clk        (clk),
  .rst        (rst),
  .level_mode (level_mode),
  .comp_in    (comp_in),
  .hit_out    (hit_out),
  .fire_vec   (fire_vec)
);

// File: tb/test_hit_detect_array.sv
`timescale 1ns/100ps
module test_hit_detect_array;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         level_mode = 1'b1;
  logic [N-1:0] comp_in = '0;
  logic [N-1:0] hit_out;
  logic [N-1:0] h0 = '0, h1 = '0, h2 = '0;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  hit_detect_array #(.NCH(N), .SYNC_DEPTH(2)) i_hit_detect_array (
    .clk(clk), .rst(rst), .level_mode(level_mode), .comp_in(comp_in), .hit_out(hit_out)
  );

  // Bench's own record of the inputs at each rising edge.
  always @(posedge clk) begin
    h2 <= h1; h1 <= h0; h0 <= comp_in;
  end

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: hit_out=%b expected %b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One-shot pulse on mask m rising ph ns after a falling edge.
  // w = 0: sub-cycle pulse; otherwise high across w rising edges.
  task automatic one_pulse(input logic [N-1:0] m, input int w, input real ph, input string req);
    @(negedge clk);
    #(ph) comp_in = comp_in | m;
    if (w == 0) #(0.3) comp_in = comp_in & ~m;
    for (int cyc = 0; cyc < w + 10; cyc++) begin
      @(negedge clk);
      chk((cyc == 2) ? req : "R5", hit_out, (cyc == 2) ? m : '0);
      if (w > 0 && cyc == w - 1) #(0.5) comp_in = comp_in & ~m;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    n_err++;
    $display("FAIL watchdog: hit_out=%b expected run end", hit_out);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    // R1 reset in level mode with all comparators high
    comp_in = '1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 in reset", hit_out, '0);
    end
    rst = 1'b0;
    @(negedge clk); chk("R1 release+0", hit_out, '0);
    @(negedge clk); chk("R1 release+1", hit_out, '0);
    @(negedge clk); chk("R2 first level", hit_out, '1);

    // R2 level sweep: hit after edge t equals input at edge t-2
    for (int n = 0; n < 64; n++) begin
      @(negedge clk);
      chk("R2 level sweep", hit_out, h2);
      #(1.0) comp_in = N'((n * 7) ^ (n >> 1) ^ (n >> 3));
    end
    @(negedge clk); #(1.0) comp_in = '0;
    idle(4);

    // R3 sub-cycle pulse in level mode is not seen
    @(negedge clk);
    #(0.5) comp_in = 4'b0101;
    #(1.0) comp_in = '0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R3 short pulse lost", hit_out, '0);
    end
    idle(4);

    // Switch to one-shot
    level_mode = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R5 idle one-shot", hit_out, '0);
    end

    // R4 R5 R6: widths x phases, back-to-back on the same channels
    for (int wi = 0; wi < 6; wi++) begin
      for (int pi = 0; pi < 3; pi++) begin
        int w;
        logic [N-1:0] m;
        w = (wi == 0) ? 0 : (wi == 5 ? 9 : wi);
        m = N'(1 << ((wi + pi) % N)) | ((pi == 1) ? N'(4'b1000) : N'(0));
        one_pulse(m, w, 0.4 + 0.8 * pi, (wi == 0) ? "R4 stretched" : "R4 R6 hit");
      end
    end

    // R7 staggered channels
    @(negedge clk); #(1.0) comp_in[1] = 1'b1;
    @(negedge clk); chk("R7 k", hit_out, '0); #(1.0) comp_in[3] = 1'b1;
    @(negedge clk); chk("R7 k+1", hit_out, '0);
    @(negedge clk); chk("R7 ch1 hit", hit_out, 4'b0010);
    @(negedge clk); chk("R7 ch3 hit", hit_out, 4'b1000); #(0.5) comp_in[1] = 1'b0;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      chk("R7 quiet", hit_out, '0);
      if (i == 2) #(0.5) comp_in[3] = 1'b0;
    end

    // R8 comparator high across reset release in one-shot mode
    @(negedge clk); rst = 1'b1; #(1.0) comp_in[0] = 1'b1;
    idle(3);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R8 held high", hit_out, '0);
    end
    #(0.5) comp_in[0] = 1'b0;
    idle(6);
    one_pulse(4'b0001, 2, 1.0, "R8 new pulse");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule